// File: doc/BRIEF.md
# Supply reset and watchdog supervisor

This block generates the system reset and a watchdog alarm for a processor subsystem. It watches two digital "rail is above its threshold" flags, one for the main supply and one for a secondary rail, and the two lines of a serial bus. The secondary-rail flag is passed straight through as a fail indication. The reset is held whenever the main rail is low. It is released only after the rail has stayed good for a programmable power-up delay.

The watchdog counts milliseconds from a tick input. The number of ticks per millisecond is a parameter. Software keeps the watchdog alive by putting a bus start condition followed by a stop condition on the serial lines. If no such pair completes within the selected period, the active-low watchdog output pulses low for a fixed alarm time. The watchdog then starts counting again.

An 8-bit fault register records what went wrong. Software arms it by writing ones. Each monitored failure clears its own bit, and the bit stays cleared until software writes it again. The serial lines are assumed to be synchronous to the clock already.

Top module: `supply_supervisor`

## Requirements
- R1: `reset_n_o` is low while `rst_n` is low, and it is low from the clock edge that follows any cycle in which `main_ok_i` is low.
- R2: Once `main_ok_i` is high, `reset_n_o` rises after the selected number of ticks: `pup_sel_i` 00 selects 50 ms, 01 selects 200 ms, 10 selects 400 ms and 11 selects 800 ms. Each millisecond is TICKS_PER_MS ticks. While `main_ok_i` stays high, a released reset stays released.
- R3: `wd_sel_i` selects the watchdog period: 00 is 1400 ms, 01 is 200 ms and 10 is 25 ms. With 11 the watchdog is disabled and `wdo_n_o` stays high.
- R4: The watchdog count restarts only when a stop (SDA rises while SCL is high) follows a start (SDA falls while SCL is high). A start alone does not restart it. A stop without an earlier start does not restart it either.
- R5: On expiry, `wdo_n_o` goes low for 200 ms after the 1400 ms or 200 ms period, and for 25 ms after the 25 ms period. It then returns high and a new period begins from zero.
- R6: `aux_fail_o` is the inverse of `aux_ok_i` as sampled at the previous clock edge, with no power-up delay.
- R7: `fault_o` is 8'h00 after `rst_n`. A write of `fault_wdata_i` stores only bits 7, 6 and 4. The other bits always read zero.
- R8: Bit 7 is cleared while `main_ok_i` is low, bit 6 while `aux_ok_i` is low, and bit 4 on a watchdog expiry. A fault never sets a bit, and a cleared bit stays cleared until it is written.
- R9: While `reset_n_o` is low the watchdog count is held at zero and `wdo_n_o` is high. After release, the full period elapses before the first alarm.
- R10: A change of `wd_sel_i` restarts the watchdog count from zero, so the new period applies at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | Timebase pulse, TICKS_PER_MS per millisecond |
| main_ok_i | input | 1 | Main rail above its threshold |
| aux_ok_i | input | 1 | Secondary rail above its threshold |
| scl_i | input | 1 | Serial clock line, synchronous |
| sda_i | input | 1 | Serial data line, synchronous |
| pup_sel_i | input | 2 | Power-up delay select |
| wd_sel_i | input | 2 | Watchdog period select |
| fault_wr_i | input | 1 | Write strobe for the fault register |
| fault_wdata_i | input | 8 | Fault register write data |
| reset_n_o | output | 1 | Active-low system reset |
| aux_fail_o | output | 1 | Secondary rail failed |
| wdo_n_o | output | 1 | Active-low watchdog alarm |
| fault_o | output | 8 | Fault register contents |

## Verification
Some properties are checked on every cycle:
- reset drops one edge after the main rail fails and stays released while the rail holds;
- the alarm is quiet in reset, when disabled, and just after a period change;
- the fault register never sets a bit by itself and keeps its unused bits at zero;
- the secondary fail flag tracks its input.

The lengths of the power-up delays, watchdog periods and alarm pulses are measured by the bench scenarios against its own tables. So is the rule that only a start followed by a stop restarts the watchdog, and the cause bits that each failure leaves behind.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic {WD_RUN, WD_BARK} wd_state_e;

  localparam logic [1:0] WD_OFF        = 2'b11;
  localparam int         FLT_MAIN_BIT  = 7;
  localparam int         FLT_AUX_BIT   = 6;
  localparam int         FLT_WD_BIT    = 4;
  localparam logic [7:0] FLT_LIVE_MASK = 8'hD0;

  // power-up delay in milliseconds
  function automatic int unsigned por_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   return 50;
      2'b01:   return 200;
      2'b10:   return 400;
      default: return 800;
    endcase
  endfunction

  // watchdog period in milliseconds, zero when disabled
  function automatic int unsigned wd_period_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1400;
      2'b01:   return 200;
      2'b10:   return 25;
      default: return 0;
    endcase
  endfunction

  // alarm pulse length in milliseconds
  function automatic int unsigned wd_pulse_ms(input logic [1:0] sel);
    return (sel == 2'b10) ? 25 : 200;
  endfunction

  function automatic int unsigned ms_to_ticks(input int unsigned ms, input int unsigned tpm);
    return ms * tpm;
  endfunction

endpackage

// File: rtl/sup_bus_events.sv
module sup_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data line moves while the clock line is high on both samples
  assign start_o = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o  = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       main_ok_i,
  input  logic [1:0] pup_sel_i,
  output logic       sys_ok_o
);
  import sup_pkg::*;

  localparam int MAX_TICKS = 800 * TICKS_PER_MS;
  localparam int LIM_W     = $clog2(MAX_TICKS + 1) + 1;

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit;
  logic             por_expire;

  assign limit      = LIM_W'(ms_to_ticks(por_ms(pup_sel_i), TICKS_PER_MS));
  assign por_expire = main_ok_i && !sys_ok_o && tick_i && ((cnt_q + 1'b1) >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_ok_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!main_ok_i) begin
      sys_ok_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!sys_ok_o && tick_i) begin
      if (por_expire) begin
        sys_ok_o <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_reset_on_fail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !main_ok_i |=> !sys_ok_o);

  assert_release_needs_rail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_ok_o) |-> $past(main_ok_i));

  assert_release_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ok_o && main_ok_i) |=> sys_ok_o);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       sys_ok_i,
  input  logic [1:0] wd_sel_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       wdo_n_o,
  output logic       timeout_o
);
  import sup_pkg::*;

  localparam int MAX_TICKS = 1400 * TICKS_PER_MS;
  localparam int LIM_W     = $clog2(MAX_TICKS + 1) + 1;

  wd_state_e        state_q;
  logic [LIM_W-1:0] cnt_q;
  logic [1:0]       sel_q;
  logic             armed_q;

  logic [LIM_W-1:0] period_lim, pulse_lim;
  logic             sel_change, wd_off, hold, kick, run_done, bark_done;

  assign period_lim = LIM_W'(ms_to_ticks(wd_period_ms(wd_sel_i), TICKS_PER_MS));
  assign pulse_lim  = LIM_W'(ms_to_ticks(wd_pulse_ms(wd_sel_i), TICKS_PER_MS));
  assign sel_change = (sel_q != wd_sel_i);
  assign wd_off     = (wd_sel_i == WD_OFF);
  assign hold       = !sys_ok_i || wd_off || sel_change;
  assign kick       = (state_q == WD_RUN) && armed_q && stop_i;
  assign run_done   = (state_q == WD_RUN) && tick_i && ((cnt_q + 1'b1) >= period_lim);
  assign bark_done  = (state_q == WD_BARK) && tick_i && ((cnt_q + 1'b1) >= pulse_lim);
  assign timeout_o  = run_done && !hold && !kick;
  assign wdo_n_o    = (state_q != WD_BARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_RUN;
      cnt_q   <= '0;
      sel_q   <= WD_OFF;
      armed_q <= 1'b0;
    end else begin
      sel_q <= wd_sel_i;
      if (hold) begin
        state_q <= WD_RUN;
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (state_q == WD_RUN) begin
        if (kick) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          if (start_i) armed_q <= 1'b1;
          if (run_done) begin
            state_q <= WD_BARK;
            cnt_q   <= '0;
            armed_q <= 1'b0;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else begin
        armed_q <= 1'b0;
        if (bark_done) begin
          state_q <= WD_RUN;
          cnt_q   <= '0;
        end else if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ok_i |=> (wdo_n_o && cnt_q == '0));

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> wdo_n_o);

  assert_sel_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (cnt_q == '0 && wdo_n_o));

  assert_bark_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdo_n_o) |-> $past(timeout_o));

  assert_kick_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !armed_q && !hold && !tick_i && state_q == WD_RUN) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/sup_fault_log.sv
module sup_fault_log (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_ok_i,
  input  logic       aux_ok_i,
  input  logic       wd_timeout_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] fault_o,
  output logic       aux_fail_o
);
  import sup_pkg::*;

  logic [7:0] clr_vec;
  logic [7:0] base;

  always_comb begin
    clr_vec               = '0;
    clr_vec[FLT_MAIN_BIT] = !main_ok_i;
    clr_vec[FLT_AUX_BIT]  = !aux_ok_i;
    clr_vec[FLT_WD_BIT]   = wd_timeout_i;
  end

  assign base = wr_i ? wdata_i : fault_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o    <= '0;
      aux_fail_o <= 1'b0;
    end else begin
      fault_o    <= base & ~clr_vec & FLT_LIVE_MASK;
      aux_fail_o <= !aux_ok_i;
    end
  end

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o & ~FLT_LIVE_MASK) == 8'h00);

  assert_never_set_by_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((fault_o & ~$past(fault_o)) == 8'h00));

  assert_aux_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (aux_fail_o == !$past(aux_ok_i)));

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int TICKS_PER_MS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       main_ok_i,
  input  logic       aux_ok_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] pup_sel_i,
  input  logic [1:0] wd_sel_i,
  input  logic       fault_wr_i,
  input  logic [7:0] fault_wdata_i,
  output logic       reset_n_o,
  output logic       aux_fail_o,
  output logic       wdo_n_o,
  output logic [7:0] fault_o
);
  logic bus_start, bus_stop, wd_timeout, sys_ok;

  sup_bus_events u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (bus_start),
    .stop_o  (bus_stop)
  );

  sup_por_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_por (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .main_ok_i (main_ok_i),
    .pup_sel_i (pup_sel_i),
    .sys_ok_o  (sys_ok)
  );

  sup_watchdog #(.TICKS_PER_MS(TICKS_PER_MS)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .sys_ok_i  (sys_ok),
    .wd_sel_i  (wd_sel_i),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .wdo_n_o   (wdo_n_o),
    .timeout_o (wd_timeout)
  );

  sup_fault_log u_flt (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_ok_i    (main_ok_i),
    .aux_ok_i     (aux_ok_i),
    .wd_timeout_i (wd_timeout),
    .wr_i         (fault_wr_i),
    .wdata_i      (fault_wdata_i),
    .fault_o      (fault_o),
    .aux_fail_o   (aux_fail_o)
  );

  assign reset_n_o = sys_ok;

endmodule

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb_top;
  localparam int TPM = 2;
  localparam int TOL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic main_ok = 1'b0, aux_ok = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [1:0] pup_sel = 2'b01, wd_sel = 2'b11;
  logic fwr = 1'b0;
  logic [7:0] fwd = 8'h00;
  logic reset_n, aux_fail, wdo_n;
  logic [7:0] fault;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  supply_supervisor #(.TICKS_PER_MS(TPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .main_ok_i(main_ok), .aux_ok_i(aux_ok),
    .scl_i(scl), .sda_i(sda), .pup_sel_i(pup_sel), .wd_sel_i(wd_sel),
    .fault_wr_i(fwr), .fault_wdata_i(fwd), .reset_n_o(reset_n), .aux_fail_o(aux_fail),
    .wdo_n_o(wdo_n), .fault_o(fault));

  // expected timings, table form
  int por_tab [4] = '{50, 200, 400, 800};
  int per_tab [4] = '{1400, 200, 25, 0};
  function automatic int exp_por(input logic [1:0] s); return por_tab[s] * TPM; endfunction
  function automatic int exp_per(input logic [1:0] s); return per_tab[s] * TPM; endfunction
  function automatic int exp_pulse(input logic [1:0] s);
    return ((per_tab[s] == 25) ? 25 : 200) * TPM;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_win(input string tag, input int act, input int exp);
    total++;
    if (act < exp - TOL || act > exp + TOL) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, TOL);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_reset_high(output int n);
    n = 0;
    while (reset_n !== 1'b1 && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_wdo(input logic lvl, output int n);
    n = 0;
    while (wdo_n !== lvl && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic write_fault(input logic [7:0] v);
    @(negedge clk); fwr = 1'b1; fwd = v;
    @(negedge clk); fwr = 1'b0;
  endtask

  task automatic bus_start_stop();
    sda = 1'b0; cyc(2); scl = 1'b0; cyc(2);
    scl = 1'b1; cyc(2); sda = 1'b1; cyc(2);
  endtask

  task automatic bus_start_only();
    sda = 1'b0; cyc(2); scl = 1'b0; cyc(2);
    sda = 1'b1; cyc(2); scl = 1'b1; cyc(2);
  endtask

  task automatic bus_stop_only();
    scl = 1'b0; cyc(2); sda = 1'b0; cyc(2);
    scl = 1'b1; cyc(2); sda = 1'b1; cyc(2);
  endtask

  task automatic restart_wd(input logic [1:0] s);
    @(negedge clk); wd_sel = 2'b11;
    @(negedge clk); wd_sel = s;
  endtask

  initial begin
    int n, n2, r;
    bit ok;
    logic [1:0] s;
    logic [7:0] v;
    r = $urandom(32'd2024);
    cyc(3);
    // R1 / R7 reset state
    check_eq("R1 reset low in block reset", reset_n, 0);
    check_eq("R7 fault zero after reset", fault, 0);
    check_eq("R9 wdo high in reset", wdo_n, 1);
    rst_n = 1'b1; aux_ok = 1'b1;
    cyc(2);
    @(negedge clk); main_ok = 1'b1;
    wait_reset_high(n);
    check_win("R2 default power-up delay", n, exp_por(2'b01));

    // R7 masked writes, random values
    write_fault(8'hFF);
    check_eq("R7 arm reads live bits", fault, 8'hD0);
    for (int i = 0; i < 6; i++) begin
      v = 8'($urandom);
      write_fault(v);
      check_eq("R7 random write", fault, v & 8'hD0);
    end

    // R6 / R8 secondary rail
    write_fault(8'hFF);
    @(negedge clk); aux_ok = 1'b0;
    @(negedge clk);
    check_eq("R6 aux fail follows", aux_fail, 1);
    check_eq("R8 aux clears bit 6", fault, 8'h90);
    aux_ok = 1'b1;
    @(negedge clk);
    check_eq("R6 aux fail clears", aux_fail, 0);
    cyc(3);
    check_eq("R8 bit 6 stays cleared", fault, 8'h90);
    write_fault(8'hFF);

    // R1 / R2 each delay select, then random ones
    for (int i = 0; i < 7; i++) begin
      s = (i < 4) ? 2'(i) : 2'($urandom);
      @(negedge clk); main_ok = 1'b0; pup_sel = s;
      @(negedge clk);
      check_eq("R1 reset on rail fail", reset_n, 0);
      cyc(5);
      main_ok = 1'b1;
      wait_reset_high(n);
      check_win("R2 power-up delay select", n, exp_por(s));
    end
    check_eq("R8 main fail clears bit 7", fault, 8'h50);
    write_fault(8'hFF);
    pup_sel = 2'b01;

    // R3 / R5 short period
    @(negedge clk); wd_sel = 2'b10;
    wait_wdo(1'b0, n);
    check_win("R3 period 25ms", n, exp_per(2'b10));
    wait_wdo(1'b1, n);
    check_win("R5 pulse after 25ms period", n, exp_pulse(2'b10));
    check_eq("R8 watchdog clears bit 4", fault, 8'hC0);
    wait_wdo(1'b0, n);
    check_win("R5 count resumes from zero", n, exp_per(2'b10));
    wait_wdo(1'b1, n);

    // R4 kicks keep alarm away
    restart_wd(2'b01);
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < 250; c++) begin @(negedge clk); if (wdo_n !== 1'b1) ok = 1'b0; end
      bus_start_stop();
    end
    check_eq("R4 start then stop restarts", int'(ok), 1);

    // R4 start only
    restart_wd(2'b01);
    cyc(250); bus_start_only();
    wait_wdo(1'b0, n);
    check_win("R4 start alone no restart", n + 258, exp_per(2'b01));
    wait_wdo(1'b1, n);
    check_win("R5 pulse after 200ms period", n, exp_pulse(2'b01));

    // R4 stop only
    restart_wd(2'b01);
    cyc(250); bus_stop_only();
    wait_wdo(1'b0, n);
    check_win("R4 stop alone no restart", n + 258, exp_per(2'b01));
    wait_wdo(1'b1, n);

    // R3 / R5 long period
    restart_wd(2'b00);
    wait_wdo(1'b0, n);
    check_win("R3 period 1400ms", n, exp_per(2'b00));
    wait_wdo(1'b1, n);
    check_win("R5 pulse after 1400ms period", n, exp_pulse(2'b00));

    // R3 disabled
    @(negedge clk); wd_sel = 2'b11;
    ok = 1'b1;
    for (int c = 0; c < 3000; c++) begin @(negedge clk); if (wdo_n !== 1'b1) ok = 1'b0; end
    check_eq("R3 disabled stays quiet", int'(ok), 1);

    // R9 held in reset
    @(negedge clk); wd_sel = 2'b10; main_ok = 1'b0;
    ok = 1'b1;
    for (int c = 0; c < 300; c++) begin @(negedge clk); if (wdo_n !== 1'b1) ok = 1'b0; end
    check_eq("R9 watchdog held in reset", int'(ok), 1);
    main_ok = 1'b1;
    wait_reset_high(n);
    wait_wdo(1'b0, n2);
    check_win("R9 period from release", n2, exp_per(2'b10));
    wait_wdo(1'b1, n);

    // R10 period change
    restart_wd(2'b00);
    cyc(1000);
    wd_sel = 2'b10;
    wait_wdo(1'b0, n);
    check_win("R10 new period applies from change", n, exp_per(2'b10));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule